// File: doc/BRIEF.md
# Second-Order Sigma-Delta Bitstream Modulator

This block is a digital second-order sigma-delta modulator. It takes a signed 16-bit sample and produces a 1-bit stream in which the fraction of ones is a linear function of the sample value. It also produces a bit clock that frames the stream on a serial data line. It serves as a stand-in for an isolated current-sense modulator when a decimation filter is under test. A one-cycle enable pulse sets the bit rate. Each pulse advances the modulator by exactly one step, and the sample input is read only in that cycle.

The loop has two saturating integrators in cascade followed by a sign quantizer. The quantizer's decision is fed back to both integrators as plus or minus full scale. Full scale is 32768, so the working span of plus or minus 20480 maps to ones densities of 18.75% to 81.25%. Any sample whose magnitude is above 30000 is clamped before the loop. A receiver takes each data bit on the rising edge of the bit clock that follows the edge that launched it.

Top module: `sdm_bitstream_mod`

## Requirements
- R1: While `rst_n` is low at a clock edge, both outputs are 0 after that edge and both integrators are cleared, even if `step_en` is high in that cycle.
- R2: At each step, the quantizer decision is 1 when the second integrator is zero or positive. The feedback is +32768 for a 1 and -32768 for a 0. The first integrator adds (clamped sample - feedback). The second integrator then adds (new first integrator - feedback). Both integrators are 24 bits wide and saturate rather than wrap.
- R3: With a sample of 0, the count of ones over 32768 steps after reset lies within 0.1% of 50%, that is 16384 plus or minus 32.
- R4: With a sample of +20480, the count over 32768 steps lies within plus or minus 32 of 26624 (81.25%). With -20480, it lies within plus or minus 32 of 6144 (18.75%).
- R5: A sample above +30000 is treated as +30000, and a sample below -30000 is treated as -30000. Samples of 32767 and 30000 therefore give identical streams, and so do -32768 and -30000.
- R6: In a cycle where `step_en` is low, the sample input has no effect and `sdata_o` keeps its value.
- R7: `sdata_o` (1 meaning a one) changes only at the edge that samples `step_en` high, which is the same edge at which `bit_clk_o` goes high.
- R8: `bit_clk_o` rises at each step edge. It stays high for max(1, floor(P/2)) clocks and then goes low. P is the number of clocks between this step edge and the previous one. For the first step after reset, P counts clocks from reset release, and P saturates at 255.
- R9: After reset, `bit_clk_o` stays low until the first step edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | One-cycle pulse; one modulator step per pulse |
| sample_i | input | 16 | Signed two's complement sample, read only when step_en is high |
| bit_clk_o | output | 1 | Bit clock framing the serial stream |
| sdata_o | output | 1 | Serial data bit, launched at the bit clock rising edge |

## Verification
Reset and a step pulse can occur in the same cycle. The bench holds `step_en` high throughout every reset and then checks that both outputs are zero and that the bit clock stays low until a real step arrives. Integrator saturation and input clamping can also act on the same step. The bench drives out-of-range samples and compares each output bit, clock by clock, against a reference model that applies the clamp and the saturation limits as stated. It also confirms that streams from clamped and unclamped samples are identical.

// File: rtl/sdm_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the sigma-delta bitstream modulator.
// Assumes integrators are wider than the sample by at least three bits.
package sdm_pkg;
    localparam int SDM_IN_W    = 16;     // sample width
    localparam int SDM_ACC_W   = 24;     // integrator width
    localparam int SDM_CLAMP   = 30000;  // input magnitude limit
    localparam int SDM_CNT_W   = 8;      // bit-period counter width
    localparam int SDM_ORDER   = 2;      // number of cascaded integrators

    typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} bclk_phase_e;
endpackage

// File: rtl/sdm_input_clamp.sv
`timescale 1ns/1ps
// Limits a signed sample to +/-LIM before it enters the loop.
// Assumes LIM fits in IN_W-1 magnitude bits.
module sdm_input_clamp #(
    parameter int IN_W = sdm_pkg::SDM_IN_W,
    parameter int LIM  = sdm_pkg::SDM_CLAMP
) (
    input  logic signed [IN_W-1:0] sample_i,
    output logic signed [IN_W-1:0] clamped_o
);
    localparam logic signed [IN_W-1:0] LIM_P = IN_W'(LIM);
    localparam logic signed [IN_W-1:0] LIM_N = -LIM_P;

    // select the sample or the nearer limit
    always_comb begin
        if (sample_i > LIM_P)
            clamped_o = LIM_P;
        else if (sample_i < LIM_N)
            clamped_o = LIM_N;
        else
            clamped_o = sample_i;
    end
endmodule

// File: rtl/sdm_sat_integrator.sv
`timescale 1ns/1ps
// One saturating accumulator: acc += add - sub on each step.
// Exposes the next value so a following stage can use it in the same step.
// Assumes add and sub are already sign-extended to W bits.
module sdm_sat_integrator #(
    parameter int W = sdm_pkg::SDM_ACC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic signed [W-1:0] add_i,
    input  logic signed [W-1:0] sub_i,
    output logic signed [W-1:0] acc_o,
    output logic signed [W-1:0] acc_next_o
);
    localparam logic signed [W+1:0] MAX_V = {2'b00, 1'b0, {(W-1){1'b1}}};
    localparam logic signed [W+1:0] MIN_V = {2'b11, 1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0] acc_q;
    logic signed [W+1:0] sum_w;

    // wide sum with two guard bits, then clip to the W-bit range
    always_comb begin
        sum_w = {{2{acc_q[W-1]}}, acc_q} + {{2{add_i[W-1]}}, add_i}
              - {{2{sub_i[W-1]}}, sub_i};
        if (sum_w > MAX_V)
            acc_next_o = MAX_V[W-1:0];
        else if (sum_w < MIN_V)
            acc_next_o = MIN_V[W-1:0];
        else
            acc_next_o = sum_w[W-1:0];
    end

    // state register, advanced only on a step
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (step_en)
            acc_q <= acc_next_o;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/sdm_loop.sv
`timescale 1ns/1ps
// Second-order noise-shaping loop: cascaded integrators, sign quantizer,
// full-scale feedback into every stage. The decision comes from registered
// state, so it is valid for the whole step cycle.
module sdm_loop #(
    parameter int IN_W  = sdm_pkg::SDM_IN_W,
    parameter int ACC_W = sdm_pkg::SDM_ACC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_en,
    input  logic signed [IN_W-1:0] x_i,
    output logic                   bit_o
);
    localparam int ORDER = sdm_pkg::SDM_ORDER;
    localparam logic signed [ACC_W-1:0] FB_POS = ACC_W'(1) << (IN_W - 1);

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] stage_in [ORDER];
    logic signed [ACC_W-1:0] acc_q    [ORDER];
    logic signed [ACC_W-1:0] acc_nx   [ORDER];

    // sign-extend the sample and pick the feedback level
    always_comb begin
        x_ext = {{(ACC_W-IN_W){x_i[IN_W-1]}}, x_i};
        fb    = bit_o ? FB_POS : -FB_POS;
    end

    // integrator chain: first stage takes the sample, later ones the previous stage
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign stage_in[k] = x_ext;
        end else begin : g_tail
            assign stage_in[k] = acc_nx[k-1];
        end
        sdm_sat_integrator #(.W(ACC_W)) u_int (
            .clk        (clk),
            .rst_n      (rst_n),
            .step_en    (step_en),
            .add_i      (stage_in[k]),
            .sub_i      (fb),
            .acc_o      (acc_q[k]),
            .acc_next_o (acc_nx[k])
        );
    end

    // quantizer: one when the last integrator is non-negative
    assign bit_o = ~acc_q[ORDER-1][ACC_W-1];
endmodule

// File: rtl/sdm_bit_clock.sv
`timescale 1ns/1ps
// Bit clock generator. Rises on every step and stays high for half of the
// interval that just ended (at least one clock). Assumes steps are at least
// two clocks apart for a real low phase.
module sdm_bit_clock #(
    parameter int CNT_W = sdm_pkg::SDM_CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    output logic bclk_o
);
    import sdm_pkg::*;

    logic [CNT_W-1:0] gap_q;
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] hi_cnt_q;
    logic [CNT_W-1:0] half_d;
    bclk_phase_e      phase_q;

    // half of the measured interval, never zero
    always_comb begin
        half_d = gap_q >> 1;
        if (half_d == '0)
            half_d = CNT_W'(1);
    end

    // clocks since the last step, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (step_en)
            gap_q <= CNT_W'(1);
        else if (gap_q != {CNT_W{1'b1}})
            gap_q <= gap_q + CNT_W'(1);
    end

    // high-phase length captured at each step
    always_ff @(posedge clk) begin
        if (!rst_n)
            half_q <= CNT_W'(1);
        else if (step_en)
            half_q <= half_d;
    end

    // phase and high-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_LOW;
            hi_cnt_q <= '0;
        end else if (step_en) begin
            phase_q  <= PH_HIGH;
            hi_cnt_q <= CNT_W'(1);
        end else if (phase_q == PH_HIGH) begin
            if (hi_cnt_q >= half_q)
                phase_q <= PH_LOW;
            else
                hi_cnt_q <= hi_cnt_q + CNT_W'(1);
        end
    end

    assign bclk_o = (phase_q == PH_HIGH);
endmodule

// File: rtl/sdm_bitstream_mod.sv
`timescale 1ns/1ps
// Top: clamp, second-order loop, launch register for the serial bit and the
// bit clock. The sample is read only in a step cycle; the launched bit and
// the bit clock rise share the same edge.
module sdm_bitstream_mod #(
    parameter int IN_W      = sdm_pkg::SDM_IN_W,
    parameter int ACC_W     = sdm_pkg::SDM_ACC_W,
    parameter int CLAMP_LIM = sdm_pkg::SDM_CLAMP,
    parameter int CNT_W     = sdm_pkg::SDM_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_en,
    input  logic signed [IN_W-1:0] sample_i,
    output logic                   bit_clk_o,
    output logic                   sdata_o
);
    logic signed [IN_W-1:0] x_clamped;
    logic                   loop_bit;
    logic                   sdata_q;

    sdm_input_clamp #(.IN_W(IN_W), .LIM(CLAMP_LIM)) u_clamp (
        .sample_i  (sample_i),
        .clamped_o (x_clamped)
    );

    sdm_loop #(.IN_W(IN_W), .ACC_W(ACC_W)) u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .x_i     (x_clamped),
        .bit_o   (loop_bit)
    );

    sdm_bit_clock #(.CNT_W(CNT_W)) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .bclk_o  (bit_clk_o)
    );

    // launch the step's decision onto the serial line
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdata_q <= 1'b0;
        else if (step_en)
            sdata_q <= loop_bit;
    end

    assign sdata_o = sdata_q;
endmodule

// File: rtl/sdm_checker.sv
`timescale 1ns/1ps
// Protocol checks on the modulator's ports, attached by bind.
module sdm_checker (
    input logic clk,
    input logic rst_n,
    input logic step_en,
    input logic bit_clk_o,
    input logic sdata_o
);
    logic rst_prev_q;

    // remember whether the last edge saw reset
    always_ff @(posedge clk) begin
        rst_prev_q <= rst_n;
    end

    // outputs cleared after a reset edge
    always @(negedge clk) begin
        if (rst_prev_q === 1'b0)
            AST_RST_CLEAR: assert (!bit_clk_o && !sdata_o) else $error("reset did not clear outputs"); // R1
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(sdata_o)) else $error("data moved without step"); // R6

    AST_DATA_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $past(step_en)) else $error("data change off step"); // R7

    AST_RISE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_clk_o) |-> $past(step_en)) else $error("bit clock rose off step"); // R8

    AST_NO_IDLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> !$rose(bit_clk_o)) else $error("bit clock rose while idle"); // R9
endmodule

bind sdm_bitstream_mod sdm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .bit_clk_o (bit_clk_o),
    .sdata_o   (sdata_o)
);

// File: tb/sim_sdm_bitstream_mod.sv
`timescale 1ns/1ps
module sim_sdm_bitstream_mod;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               step_en = 1'b0;
    logic signed [15:0] sample_i = '0;
    logic               bit_clk_o;
    logic               sdata_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int ones  = 0;
    logic rec [256];

    // behavioural reference state
    longint m_i1, m_i2;
    int     m_gap, m_half, m_hi;
    logic   m_bclk, m_sd;

    sdm_bitstream_mod u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .sample_i  (sample_i),
        .bit_clk_o (bit_clk_o),
        .sdata_o   (sdata_o)
    );

    always #4 clk = ~clk;

    function automatic longint sat24(input longint v);
        if (v > 64'sd8388607)  return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    // reference model written from the requirements
    always @(posedge clk) begin
        longint xc, fb;
        if (!rst_n) begin
            m_i1 = 0; m_i2 = 0; m_bclk = 0; m_sd = 0;
            m_gap = 0; m_half = 1; m_hi = 0;
        end else if (step_en) begin
            xc = sample_i;
            if (xc > 30000) xc = 30000;
            if (xc < -30000) xc = -30000;
            m_sd = (m_i2 >= 0);
            fb = m_sd ? 32768 : -32768;
            m_i1 = sat24(m_i1 + xc - fb);
            m_i2 = sat24(m_i2 + m_i1 - fb);
            m_half = (m_gap / 2 < 1) ? 1 : m_gap / 2;
            m_gap = 1;
            m_bclk = 1;
            m_hi = 1;
        end else begin
            if (m_gap < 255) m_gap++;
            if (m_bclk) begin
                if (m_hi >= m_half) m_bclk = 0;
                else m_hi++;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    // one clock: drive, wait for the edge, sample 2 ns later, compare with model
    task automatic tick(input logic en, input logic signed [15:0] x);
        step_en  = en;
        sample_i = x;
        @(posedge clk);
        #2;
        cyc++;
        check("R2", "data vs model", int'(sdata_o), int'(m_sd));
        check("R8", "bit clock vs model", int'(bit_clk_o), int'(m_bclk));
    endtask

    // reset with step held high (R1 priority)
    task automatic do_reset();
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) tick(1'b1, 16'sd1234);
        check("R1", "data after reset", int'(sdata_o), 0);
        check("R1", "bit clock after reset", int'(bit_clk_o), 0);
        rst_n = 1'b1;
    endtask

    // nbits steps of period per; idle cycles carry a scrambled sample
    task automatic run_bits(input int nbits, input int per, input logic signed [15:0] x, input logic keep);
        logic held;
        int hi;
        for (int b = 0; b < nbits; b++) begin
            tick(1'b1, x);
            held = sdata_o;
            ones += int'(sdata_o);
            if (keep && b < 256) rec[b] = sdata_o;
            if (per > 1) check("R7", "bit clock high at launch", int'(bit_clk_o), 1);
            hi = int'(bit_clk_o);
            for (int k = 1; k < per; k++) begin
                tick(1'b0, x ^ 16'sh5a5a ^ 16'(k * 977));
                check("R6", "data held while idle", int'(sdata_o), int'(held));
                hi += int'(bit_clk_o);
            end
            if (per > 2 && b > 0) check("R8", "high clocks per period", hi, per / 2);
        end
    endtask

    task automatic density(input logic signed [15:0] x, input int exp, input string req);
        do_reset();
        ones = 0;
        run_bits(32768, 1, x, 1'b0);
        total++;
        if (ones < exp - 32 || ones > exp + 32) begin
            bad++;
            $display("FAIL %s ones count for %0d: actual=%0d expected=%0d+/-32", req, x, ones, exp);
        end
    endtask

    task automatic clamp_pair(input logic signed [15:0] lim, input logic signed [15:0] over);
        logic first [256];
        int diff = 0;
        do_reset();
        run_bits(256, 2, lim, 1'b1);
        for (int i = 0; i < 256; i++) first[i] = rec[i];
        do_reset();
        run_bits(256, 2, over, 1'b1);
        for (int i = 0; i < 256; i++) if (first[i] != rec[i]) diff++;
        check("R5", "stream mismatches clamped vs limit", diff, 0);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R9: bit clock low until the first step
        for (int k = 0; k < 10; k++) begin
            tick(1'b0, 16'sd7000);
            check("R9", "bit clock before first step", int'(bit_clk_o), 0);
        end
        tick(1'b1, 16'sd0);
        check("R9", "bit clock at first step", int'(bit_clk_o), 1);
        // several patterns and periods
        run_bits(64, 4, 16'sd0, 1'b0);
        run_bits(64, 6, 16'sd5000, 1'b0);
        run_bits(64, 5, -16'sd12000, 1'b0);
        run_bits(64, 2, 16'sd20480, 1'b0);
        run_bits(128, 3, 16'sd32767, 1'b0);
        run_bits(128, 4, -16'sd32768, 1'b0);
        run_bits(32, 6, 16'sd100, 1'b0);
        // R5 clamp equivalence, both signs
        clamp_pair(16'sd30000, 16'sd32767);
        clamp_pair(-16'sd30000, -16'sd32768);
        // R3 and R4 ones density from fresh reset
        density(16'sd0, 16384, "R3");
        density(16'sd20480, 26624, "R4");
        density(-16'sd20480, 6144, "R4");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule